// File: doc/BRIEF.md
# UART Receive Status Flags

This block sits between a UART receiver's shift register and the CPU. Each time the receiver reports a finished frame, the block decides whether the new byte may move into the receive data register. It also keeps three status flags: data ready, overrun and framing error. Bit sampling, start detection and baud timing happen upstream and are not part of this block.

A byte is accepted only when the data register is free, meaning data ready is low and no framing error is pending. A frame that arrives while data ready is still high is an overrun. The overrun flag is raised and the stored byte stays in place. A frame whose stop bit was sampled low raises the framing error flag in the same cycle as data ready. No further byte is accepted until that flag is cleared.

Software clears the flags in two steps. It reads the status register, and at some later cycle it reads the data register. That data read clears all three flags.

Top module: `rx_status_flags`

## Requirements
- R1: After reset, the data ready, overrun and framing error flags are 0 and the data register holds 0.
- R2: A frame completion with a valid stop bit, arriving while data ready and framing error are both 0, sets data ready and loads the received byte into the data register one cycle later.
- R3: A frame completion with its stop bit sampled as 0 (stop_ok = 0) that is accepted into the data register sets the framing error flag in the same cycle as data ready. An accepted frame with a valid stop bit leaves the framing error flag at 0.
- R4: A frame completion while data ready is 1 sets the overrun flag one cycle later, and the data register keeps its previous byte.
- R5: A frame that causes an overrun never sets the framing error flag, even when its stop bit is 0.
- R6: While the framing error flag is 1, no received byte is transferred into the data register.
- R7: A status read (stat_rd) followed in a later cycle by a data read (data_rd) clears data ready, overrun and framing error one cycle after the data read.
- R8: A data read with no status read since the previous clearing data read leaves all three flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_done | input | 1 | One-cycle strobe: the shift register holds a finished frame |
| rx_byte | input | DATA_W | Byte held in the shift register |
| stop_ok | input | 1 | 1 when the stop bit was sampled high |
| stat_rd | input | 1 | One-cycle strobe: CPU reads the status register |
| data_rd | input | 1 | One-cycle strobe: CPU reads the data register |
| rx_data | output | DATA_W | Receive data register |
| rdy_flag | output | 1 | Data ready flag |
| ovr_flag | output | 1 | Overrun flag |
| ferr_flag | output | 1 | Framing error flag |

## Verification
The assertions assume that a frame completion never falls in the same cycle as a data read. With that assumption, every flag change traces back to a single cause. The assertions also assume that every strobe lasts exactly one cycle. The stimulus table and the directed tests keep to both rules: each row drives at most one of frame_done, stat_rd and data_rd. The status read and the data read of a clearing sequence are always placed in separate rows.

// File: rtl/rx_status_pkg.sv
package rx_status_pkg;
  // A frame may enter the data register only when it is free
  function automatic logic f_accept(input logic frame, input logic rdy, input logic fe);
    return frame && !rdy && !fe;
  endfunction

  // A frame landing on an unread byte is an overrun
  function automatic logic f_overrun(input logic frame, input logic rdy);
    return frame && rdy;
  endfunction

  // Framing error only for frames that were accepted
  function automatic logic f_frame_err(input logic accepted, input logic stop_ok);
    return accepted && !stop_ok;
  endfunction

  // Flag update: set wins over clear
  function automatic logic f_next_flag(input logic cur, input logic set, input logic clr);
    return set ? 1'b1 : (clr ? 1'b0 : cur);
  endfunction
endpackage

// File: rtl/rx_clear_seq.sv
module rx_clear_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic stat_rd,
  input  logic data_rd,
  output logic clr_ev
);
  logic armed_q;

  assign clr_ev = data_rd && armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       armed_q <= 1'b0;
    else if (data_rd) armed_q <= 1'b0;
    else if (stat_rd) armed_q <= 1'b1;
  end
endmodule

// File: rtl/rx_xfer_ctrl.sv
module rx_xfer_ctrl
  import rx_status_pkg::*;
(
  input  logic frame_done,
  input  logic stop_ok,
  input  logic rdy,
  input  logic fe,
  output logic xfer_ev,
  output logic ovr_ev,
  output logic fe_ev
);
  always_comb begin
    xfer_ev = f_accept(frame_done, rdy, fe);
    ovr_ev  = f_overrun(frame_done, rdy);
    fe_ev   = f_frame_err(xfer_ev, stop_ok);
  end
endmodule

// File: rtl/rx_flag_regs.sv
module rx_flag_regs
  import rx_status_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_ev,
  input  logic              ovr_ev,
  input  logic              fe_ev,
  input  logic              clr_ev,
  input  logic [DATA_W-1:0] rx_byte,
  output logic [DATA_W-1:0] data_q,
  output logic              rdy_q,
  output logic              ovr_q,
  output logic              fe_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      rdy_q  <= 1'b0;
      ovr_q  <= 1'b0;
      fe_q   <= 1'b0;
    end else begin
      if (xfer_ev) data_q <= rx_byte;
      rdy_q <= f_next_flag(rdy_q, xfer_ev, clr_ev);
      ovr_q <= f_next_flag(ovr_q, ovr_ev, clr_ev);
      fe_q  <= f_next_flag(fe_q, fe_ev, clr_ev);
    end
  end
endmodule

// File: rtl/rx_status_flags.sv
module rx_status_flags #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_done,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              stop_ok,
  input  logic              stat_rd,
  input  logic              data_rd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rdy_flag,
  output logic              ovr_flag,
  output logic              ferr_flag
);
  // Named internal events, visible to the checker
  logic xfer_ev, ovr_ev, fe_ev, clr_ev;

  rx_clear_seq u_clr (
    .clk     (clk),
    .rst_n   (rst_n),
    .stat_rd (stat_rd),
    .data_rd (data_rd),
    .clr_ev  (clr_ev)
  );

  rx_xfer_ctrl u_ctrl (
    .frame_done (frame_done),
    .stop_ok    (stop_ok),
    .rdy        (rdy_flag),
    .fe         (ferr_flag),
    .xfer_ev    (xfer_ev),
    .ovr_ev     (ovr_ev),
    .fe_ev      (fe_ev)
  );

  rx_flag_regs #(.DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .xfer_ev (xfer_ev),
    .ovr_ev  (ovr_ev),
    .fe_ev   (fe_ev),
    .clr_ev  (clr_ev),
    .rx_byte (rx_byte),
    .data_q  (rx_data),
    .rdy_q   (rdy_flag),
    .ovr_q   (ovr_flag),
    .fe_q    (ferr_flag)
  );
endmodule

// File: rtl/rx_status_flags_chk.sv
module rx_status_flags_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_done,
  input logic [DATA_W-1:0] rx_byte,
  input logic              stop_ok,
  input logic              data_rd,
  input logic [DATA_W-1:0] rx_data,
  input logic              rdy_flag,
  input logic              ovr_flag,
  input logic              ferr_flag,
  input logic              clr_ev
);
  a_r2_accept_loads: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && !rdy_flag && !ferr_flag && !data_rd |=> rdy_flag && rx_data == $past(rx_byte));

  a_r3_fe_with_rdy: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && !rdy_flag && !ferr_flag && !stop_ok && !data_rd |=> rdy_flag && ferr_flag);

  a_r3_good_stop_no_fe: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && !rdy_flag && !ferr_flag && stop_ok && !data_rd |=> !ferr_flag);

  a_r4_overrun_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && rdy_flag && !data_rd |=> ovr_flag && $stable(rx_data));

  a_r5_no_fe_on_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && rdy_flag && !ferr_flag && !data_rd |=> !ferr_flag);

  a_r6_fe_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    ferr_flag |=> $stable(rx_data));

  a_r7_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ev && !frame_done |=> !rdy_flag && !ovr_flag && !ferr_flag);

  a_r3_fe_implies_rdy: assert property (@(posedge clk) disable iff (!rst_n)
    ferr_flag |-> rdy_flag);
endmodule

bind rx_status_flags rx_status_flags_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .frame_done (frame_done),
  .rx_byte    (rx_byte),
  .stop_ok    (stop_ok),
  .data_rd    (data_rd),
  .rx_data    (rx_data),
  .rdy_flag   (rdy_flag),
  .ovr_flag   (ovr_flag),
  .ferr_flag  (ferr_flag),
  .clr_ev     (clr_ev)
);

// File: tb/test_rx_status_flags.sv
module test_rx_status_flags;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_done = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic       stop_ok = 1'b1;
  logic       stat_rd = 1'b0;
  logic       data_rd = 1'b0;
  logic [7:0] rx_data;
  logic       rdy_flag, ovr_flag, ferr_flag;
  int         n_run = 0;
  int         n_fail = 0;

  always #4 clk = ~clk;

  rx_status_flags #(.DATA_W(8)) i_rx_status_flags (
    .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .rx_byte(rx_byte),
    .stop_ok(stop_ok), .stat_rd(stat_rd), .data_rd(data_rd), .rx_data(rx_data),
    .rdy_flag(rdy_flag), .ovr_flag(ovr_flag), .ferr_flag(ferr_flag)
  );

  // {req, frame, byte, stop_ok, stat_rd, data_rd, exp_rdy, exp_ovr, exp_fe, exp_data}
  localparam int NV = 16;
  localparam logic [26:0] TBL [0:NV-1] = '{
    {4'd2, 1'b1, 8'hA5, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'hA5}, // R2 accept
    {4'd2, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'hA5}, // R2 hold
    {4'd4, 1'b1, 8'h3C, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'hA5}, // R4 overrun
    {4'd7, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'hA5}, // R7 status read
    {4'd7, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'hA5}, // R7 data read clears
    {4'd3, 1'b1, 8'h5A, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h5A}, // R3 bad stop
    {4'd6, 1'b1, 8'h77, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h5A}, // R6 blocked by FE
    {4'd8, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'h5A}, // R8 unarmed read
    {4'd7, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h5A}, // R7 status read
    {4'd7, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h5A}, // R7 gap cycle
    {4'd7, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h5A}, // R7 clear
    {4'd8, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h5A}, // R8 second read
    {4'd2, 1'b1, 8'hC3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'hC3}, // R2 accept
    {4'd5, 1'b1, 8'h11, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'hC3}, // R5 no FE on overrun
    {4'd7, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'hC3}, // R7 status read
    {4'd7, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'hC3}  // R7 clear
  };

  task automatic check(input int req, input logic er, input logic eo, input logic ef,
                       input logic [7:0] ed);
    n_run++;
    if (rdy_flag !== er || ovr_flag !== eo || ferr_flag !== ef || rx_data !== ed) begin
      n_fail++;
      $display("FAIL R%0d: rdy/ovr/fe/data = %b%b%b/%h, expected %b%b%b/%h",
               req, rdy_flag, ovr_flag, ferr_flag, rx_data, er, eo, ef, ed);
    end
  endtask

  task automatic step(input logic fr, input logic [7:0] b, input logic ok,
                      input logic st, input logic dr);
    frame_done = fr; rx_byte = b; stop_ok = ok; stat_rd = st; data_rd = dr;
    @(negedge clk);
    frame_done = 1'b0; stat_rd = 1'b0; data_rd = 1'b0;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check(1, 1'b0, 1'b0, 1'b0, 8'h00); // R1 reset state
    rst_n = 1'b1;
    @(negedge clk);
    check(1, 1'b0, 1'b0, 1'b0, 8'h00); // R1 after release

    for (int i = 0; i < NV; i++) begin
      step(TBL[i][22], TBL[i][21:14], TBL[i][13], TBL[i][12], TBL[i][11]);
      check(int'(TBL[i][26:23]), TBL[i][10], TBL[i][9], TBL[i][8], TBL[i][7:0]);
    end

    // R6: FE pending, several frames never reach the data register
    step(1'b1, 8'hE1, 1'b0, 1'b0, 1'b0);
    check(3, 1'b1, 1'b0, 1'b1, 8'hE1); // R3
    step(1'b1, 8'h42, 1'b1, 1'b0, 1'b0);
    step(1'b1, 8'h99, 1'b0, 1'b0, 1'b0);
    check(6, 1'b1, 1'b1, 1'b1, 8'hE1); // R6
    // R8: data read before status read does not arm the clear
    step(1'b0, 8'h00, 1'b1, 1'b0, 1'b1);
    check(8, 1'b1, 1'b1, 1'b1, 8'hE1);
    step(1'b0, 8'h00, 1'b1, 1'b1, 1'b0);
    step(1'b0, 8'h00, 1'b1, 1'b0, 1'b1);
    check(7, 1'b0, 1'b0, 1'b0, 8'hE1); // R7
    // R2 after FE cleared, transfer resumes
    step(1'b1, 8'h6D, 1'b1, 1'b0, 1'b0);
    check(2, 1'b1, 1'b0, 1'b0, 8'h6D);
    // R1: reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    check(1, 1'b0, 1'b0, 1'b0, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule